// File: doc/BRIEF.md
# Pipelined Bit-Plane Rank-Order Filter

This block picks the element of a given rank out of a window of unsigned words. Each clock it can take a whole window of `LANES` words of `WIDTH` bits, plus a rank and an active window size. It returns one result word per accepted window, in order. Rank 1 selects the largest active word. A rank equal to the active size selects the smallest, and the middle rank gives the median.

The work is done one bit plane at a time, starting with the most significant. A chain of `WIDTH` plane stages does this work. Each stage holds one cell per lane and one programmable threshold vote. The vote decides the result bit of that plane: it is 1 when at least `rank` of the bits presented by the active lanes are 1. Each cell compares its presented bit with the vote. A lane that disagrees is knocked out: from then on its cell keeps presenting the disagreeing bit at every lower plane, so it still counts correctly as larger or smaller than the result. An input skew register array feeds each plane its bits in the cycle that plane reaches the window. An output deskew register array lines the vote bits up into one word. A valid flag, the rank and the size travel with each window, so the configuration may change on every window.

The upstream logic that builds windows from a sample stream feeds the block. It drives one window per cycle, or leaves gaps with `in_valid` low.

Top module: `rank_sel_array`

## Requirements
- R1: For a valid window, `out_word` is the rank-th largest unsigned value among the active lanes. Rank 1 gives the maximum, and a rank equal to the active lane count gives the minimum.
- R2: Each window sampled with `in_valid` high at a rising edge yields exactly one cycle of `out_valid` high, `WIDTH` rising edges later. A new window may be accepted on every edge, and results leave in the order the windows arrived.
- R3: Only lanes 0 to `in_size`-1 take part. The other lanes have no effect on the result, and an `in_size` larger than `LANES` behaves as `LANES`.
- R4: Rank 0 gives a result of all ones. A rank larger than the active lane count gives all zeros, and this includes every nonzero rank with `in_size` 0.
- R5: `in_rank` and `in_size` are captured on the same edge as the window and apply to that window alone. Different settings on back-to-back windows each give their own correct result.
- R6: While `rst_n` is low at a rising edge, `out_valid` and `out_word` become 0 after that edge. Windows in flight are discarded: after release, no `out_valid` appears until a newly accepted window comes out.
- R7: While `out_valid` is low, `out_word` keeps its last value. Cycles with `in_valid` low produce no result.
- R8: Lane j occupies `in_window[j*WIDTH +: WIDTH]` as an unsigned number, with its most significant bit at the highest index.
- R9: Equal values count once per lane. The result is the entry at position rank in the descending list that keeps duplicates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Window on `in_window` is to be filtered |
| in_window | input | LANES*WIDTH | Packed window, lane j at bits j*WIDTH upward |
| in_rank | input | $clog2(LANES+1) | Rank to select, 1 = largest |
| in_size | input | $clog2(LANES+1) | Number of active lanes, counted from lane 0 |
| out_valid | output | 1 | `out_word` holds a new result this cycle |
| out_word | output | WIDTH | Selected word |

## Verification
On every cycle, the assertions check that the correct candidate survives the vote at each plane whenever the rank is in range. They also check that out-of-range ranks force the plane vote, that reset clears the outputs, and that the result holds between valid cycles. Only the bench's scenarios can show that the word is the right rank-th largest value, that it comes out on the exact edge, and that inactive lanes, ties and per-window configuration changes are handled. The bench covers these by sweeping every window of a four-lane, three-bit instance under rotating rank and size settings, with idle gaps. It adds directed checks on lane packing, duplicate values and a reset with windows in flight.

// File: rtl/rof_pkg.sv
// Shared types for the bit-plane rank-order filter.
// A lane's state between planes is its select flag and the bit it passes down.
package rof_pkg;

    typedef struct packed {
        logic sel;   // lane still a candidate for the result
        logic data;  // bit handed to the next lower plane
    } lane_state_t;

endpackage

// File: rtl/rof_cell.sv
// One lane cell of one bit plane.
// Presents its own bit while still selected, otherwise the inherited bit,
// and drops its select once the presented bit disagrees with the plane vote.
// Assumes: vote is a function of the presented bits only (no loop through sel).
module rof_cell
    import rof_pkg::*;
(
    input  logic        own_bit,
    input  lane_state_t up,
    input  logic        vote,
    output logic        shown_bit,
    output lane_state_t down
);

    // Bit offered to the vote: own word while selected, inherited bit after knock-out
    assign shown_bit = up.sel ? own_bit : up.data;

    // Select survives only while the lane agrees with every vote so far
    assign down.sel  = up.sel & ~(vote ^ shown_bit);

    // Pass the presented bit down so a knocked-out lane keeps its side
    assign down.data = shown_bit;

endmodule

// File: rtl/rof_vote.sv
// Programmable k-out-of-m threshold for one bit plane.
// Counts ones among lanes below the active size and compares with the rank.
// Assumes: CW bits can hold LANES; sizes above LANES mask nothing extra.
module rof_vote #(
    parameter int LANES = 5,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] bits,
    input  logic [CW-1:0]    size,
    input  logic [CW-1:0]    rank,
    output logic             vote
);

    logic [CW-1:0] tally;

    // Population count of the active lanes' presented bits
    always_comb begin
        tally = '0;
        for (int j = 0; j < LANES; j++) begin
            if (CW'(j) < size) begin
                tally = tally + CW'(bits[j]);
            end
        end
    end

    // Plane result bit: at least rank active ones
    assign vote = (tally >= rank);

endmodule

// File: rtl/rof_plane.sv
// One bit plane of the filter: LANES cells sharing one threshold vote,
// followed by the pipeline register that hands lane states, the vote bit,
// the window's rank/size and its valid flag to the next plane.
// Assumes: own_bits arrive in the same cycle as the upstream lane states.
module rof_plane
    import rof_pkg::*;
#(
    parameter int LANES = 5,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] own_bits,
    input  logic [LANES-1:0] up_sel,
    input  logic [LANES-1:0] up_data,
    input  logic [CW-1:0]    rank_in,
    input  logic [CW-1:0]    size_in,
    input  logic             valid_in,
    output logic [LANES-1:0] sel_q,
    output logic [LANES-1:0] data_q,
    output logic             vote_q,
    output logic [CW-1:0]    rank_q,
    output logic [CW-1:0]    size_q,
    output logic             valid_q
);

    lane_state_t      up_st [LANES];
    lane_state_t      dn_st [LANES];
    logic [LANES-1:0] shown;
    logic [LANES-1:0] dn_sel;
    logic [LANES-1:0] dn_data;
    logic             vote;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign up_st[j] = '{sel: up_sel[j], data: up_data[j]};

        rof_cell u_cell (
            .own_bit   (own_bits[j]),
            .up        (up_st[j]),
            .vote      (vote),
            .shown_bit (shown[j]),
            .down      (dn_st[j])
        );

        assign dn_sel[j]  = dn_st[j].sel;
        assign dn_data[j] = dn_st[j].data;
    end

    rof_vote #(
        .LANES (LANES),
        .CW    (CW)
    ) u_vote (
        .bits (shown),
        .size (size_in),
        .rank (rank_in),
        .vote (vote)
    );

    // Valid flag of the window leaving this plane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_in;
        end
    end

    // Lane states, vote bit and window configuration move one plane down
    always_ff @(posedge clk) begin
        sel_q  <= dn_sel;
        data_q <= dn_data;
        vote_q <= vote;
        rank_q <= rank_in;
        size_q <= size_in;
    end

    // Checker-side views: active-lane masks and in-range rank
    logic [CW-1:0]    eff_in;
    logic [LANES-1:0] act_in;
    logic [LANES-1:0] act_q;
    logic             rank_ok_in;

    always_comb begin
        eff_in = (size_in > CW'(LANES)) ? CW'(LANES) : size_in;
        for (int j = 0; j < LANES; j++) begin
            act_in[j] = (CW'(j) < size_in);
            act_q[j]  = (CW'(j) < size_q);
        end
        rank_ok_in = (rank_in != '0) && (rank_in <= eff_in);
    end

    // R1: with an in-range rank the true result's lane is never knocked out
    a_r1_candidate_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && rank_ok_in && ((up_sel & act_in) != '0)) |=> ((sel_q & act_q) != '0));

    // R4: rank 0 always votes 1
    a_r4_rank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && rank_in == '0) |-> vote);

    // R4: a rank above the active count always votes 0
    a_r4_rank_high: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && rank_in > eff_in) |-> !vote);

endmodule

// File: rtl/rank_sel_array.sv
// Pipelined rank-order filter over a packed window of LANES unsigned words.
// Plane p resolves result bit WIDTH-1-p, p cycles after plane 0. An input skew
// array delays each plane's bits to match, and a deskew array realigns the
// vote bits into the output word. Latency is WIDTH edges, one window per clock.
// Assumes: windows are presented whole; rank and size accompany each window.
module rank_sel_array #(
    parameter  int LANES = 5,
    parameter  int WIDTH = 8,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*WIDTH-1:0] in_window,
    input  logic [CW-1:0]          in_rank,
    input  logic [CW-1:0]          in_size,
    output logic                   out_valid,
    output logic [WIDTH-1:0]       out_word
);

    logic [LANES-1:0] plane_bits [WIDTH];
    logic [LANES-1:0] own_c      [WIDTH];
    logic [LANES-1:0] sel_c      [WIDTH];
    logic [LANES-1:0] data_c     [WIDTH];
    logic [CW-1:0]    rank_c     [WIDTH];
    logic [CW-1:0]    size_c     [WIDTH];
    logic [WIDTH-1:0] valid_c;
    logic [WIDTH-1:0] vote_c;
    logic [WIDTH-1:0] result_bits;

    // Slice the window into bit planes, most significant plane first
    always_comb begin
        for (int p = 0; p < WIDTH; p++) begin
            for (int j = 0; j < LANES; j++) begin
                plane_bits[p][j] = in_window[j*WIDTH + WIDTH - 1 - p];
            end
        end
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_plane
        if (p == 0) begin : g_head
            assign own_c[0] = plane_bits[0];

            rof_plane #(
                .LANES (LANES),
                .CW    (CW)
            ) u_plane (
                .clk      (clk),
                .rst_n    (rst_n),
                .own_bits (own_c[0]),
                .up_sel   ({LANES{1'b1}}),
                .up_data  ({LANES{1'b0}}),
                .rank_in  (in_rank),
                .size_in  (in_size),
                .valid_in (in_valid),
                .sel_q    (sel_c[0]),
                .data_q   (data_c[0]),
                .vote_q   (vote_c[0]),
                .rank_q   (rank_c[0]),
                .size_q   (size_c[0]),
                .valid_q  (valid_c[0])
            );
        end else begin : g_body
            logic [LANES-1:0] skew_r [p];

            // Input skew: hold this plane's bits p cycles
            always_ff @(posedge clk) begin
                skew_r[0] <= plane_bits[p];
                for (int i = 1; i < p; i++) begin
                    skew_r[i] <= skew_r[i-1];
                end
            end

            assign own_c[p] = skew_r[p-1];

            rof_plane #(
                .LANES (LANES),
                .CW    (CW)
            ) u_plane (
                .clk      (clk),
                .rst_n    (rst_n),
                .own_bits (own_c[p]),
                .up_sel   (sel_c[p-1]),
                .up_data  (data_c[p-1]),
                .rank_in  (rank_c[p-1]),
                .size_in  (size_c[p-1]),
                .valid_in (valid_c[p-1]),
                .sel_q    (sel_c[p]),
                .data_q   (data_c[p]),
                .vote_q   (vote_c[p]),
                .rank_q   (rank_c[p]),
                .size_q   (size_c[p]),
                .valid_q  (valid_c[p])
            );
        end

        if (p == WIDTH - 1) begin : g_last_bit
            assign result_bits[0] = vote_c[p];
        end else begin : g_deskew
            localparam int D = WIDTH - 1 - p;
            logic [D-1:0] dly_r;

            // Output deskew: delay this plane's vote until the last plane is done
            always_ff @(posedge clk) begin
                dly_r[0] <= vote_c[p];
                for (int i = 1; i < D; i++) begin
                    dly_r[i] <= dly_r[i-1];
                end
            end

            assign result_bits[WIDTH-1-p] = dly_r[D-1];
        end
    end

    // Result register: loads only for a finished valid window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= valid_c[WIDTH-1];
            if (valid_c[WIDTH-1]) begin
                out_word <= result_bits;
            end
        end
    end

    // R6: reset clears the result outputs on the next edge
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0));

    // R7: result word is held while no new result is flagged
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

endmodule

// File: tb/rank_sel_array_tb.sv
// Self-checking bench: exhaustive window sweep of a 4-lane, 3-bit instance
// under rotating rank/size, plus directed packing, tie and reset cases.
module rank_sel_array_tb;

    localparam int LANES = 4;
    localparam int WIDTH = 3;
    localparam int CW    = $clog2(LANES + 1);
    localparam int WIN   = LANES * WIDTH;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic [WIN-1:0]       in_window;
    logic [CW-1:0]        in_rank;
    logic [CW-1:0]        in_size;
    logic                 out_valid;
    logic [WIDTH-1:0]     out_word;

    always #4 clk = ~clk;

    rank_sel_array #(
        .LANES (LANES),
        .WIDTH (WIDTH)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_window (in_window),
        .in_rank   (in_rank),
        .in_size   (in_size),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int               n_tests = 0;
    int               n_fail  = 0;
    logic [WIDTH-1:0] exp_q [$];
    int               due_q [$];
    string            tag_q [$];
    logic             mon_en = 1'b0;
    logic [WIDTH-1:0] last_word = '0;
    int               prev_rank = -1;
    int               prev_size = -1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected result from the requirements (R1, R3, R4, R9)
    function automatic logic [WIDTH-1:0] ref_word(logic [WIN-1:0] w, int rank, int size);
        int eff;
        eff = (size > LANES) ? LANES : size;
        if (rank == 0) return '1;
        if (rank > eff) return '0;
        for (int j = 0; j < eff; j++) begin
            int v;
            int gt;
            int ge;
            v  = int'(w[j*WIDTH +: WIDTH]);
            gt = 0;
            ge = 0;
            for (int i = 0; i < eff; i++) begin
                if (int'(w[i*WIDTH +: WIDTH]) > v) gt++;
                if (int'(w[i*WIDTH +: WIDTH]) >= v) ge++;
            end
            if (gt < rank && rank <= ge) return WIDTH'(v);
        end
        return '0;
    endfunction

    function automatic string tag_of(int rank, int size);
        int eff;
        eff = (size > LANES) ? LANES : size;
        if (rank == 0 || rank > eff) return "R4";
        if (size != LANES) return "R3";
        return "R1";
    endfunction

    // Drive one window; result expected WIDTH edges after the sampling edge
    task automatic send(input logic [WIN-1:0] w, input int rank, input int size, input string tag);
        string t;
        @(negedge clk);
        in_valid  = 1'b1;
        in_window = w;
        in_rank   = CW'(rank);
        in_size   = CW'(size);
        t = (tag == "") ? tag_of(rank, size) : tag;
        if (prev_rank >= 0 && (rank != prev_rank || size != prev_size)) t = {t, " R5"};
        prev_rank = rank;
        prev_size = size;
        exp_q.push_back(ref_word(w, rank, size));
        due_q.push_back(cyc + 1 + WIDTH);
        tag_q.push_back(t);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [WIN-1:0] pack4(int a, int b, int c, int d);
        logic [WIN-1:0] w;
        w = '0;
        w[0*WIDTH +: WIDTH] = WIDTH'(a);
        w[1*WIDTH +: WIDTH] = WIDTH'(b);
        w[2*WIDTH +: WIDTH] = WIDTH'(c);
        w[3*WIDTH +: WIDTH] = WIDTH'(d);
        return w;
    endfunction

    // Output monitor: timing (R2), value, hold while idle (R7)
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 R6 unexpected out_valid", 1, 0);
                end else begin
                    logic [WIDTH-1:0] e;
                    int               d;
                    string            t;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    t = tag_q.pop_front();
                    check(cyc == d, "R2 latency", cyc, d);
                    check(out_word == e, t, int'(out_word), int'(e));
                end
                last_word = out_word;
            end else begin
                check(out_word == last_word, "R7 hold", int'(out_word), int'(last_word));
                if (due_q.size() > 0 && due_q[0] <= cyc) begin
                    check(1'b0, "R2 missing out_valid", 0, 1);
                    void'(exp_q.pop_front());
                    void'(due_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2 watchdog", 0, 1);
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_window = '0;
        in_rank   = '0;
        in_size   = '0;
        repeat (3) @(negedge clk);
        // R6: reset state
        check(out_valid == 1'b0, "R6 reset out_valid", int'(out_valid), 0);
        check(out_word == '0, "R6 reset out_word", int'(out_word), 0);
        last_word = '0;
        rst_n     = 1'b1;
        mon_en    = 1'b1;

        // R8: lane packing, lane0=5 lane1=2 lane2=7 lane3=1
        send(pack4(5, 2, 7, 1), 1, 1, "R8");   // only lane 0 -> 5
        send(pack4(5, 2, 7, 1), 2, 2, "R8");   // lanes 0,1 -> 2
        send(pack4(5, 2, 7, 1), 1, 3, "R8");   // lanes 0..2 max -> 7
        send(pack4(5, 2, 7, 1), 4, 4, "R8");   // min of all -> 1
        // R9: ties counted per lane
        send(pack4(3, 3, 3, 3), 2, 4, "R9");   // -> 3
        send(pack4(6, 1, 6, 1), 2, 4, "R9");   // -> 6
        send(pack4(6, 1, 6, 1), 3, 4, "R9");   // -> 1
        // R3: lanes beyond size ignored even when holding extremes
        send(pack4(2, 4, 0, 7), 1, 2, "R3");   // -> 4
        send(pack4(2, 4, 0, 7), 2, 6, "R3");   // size 6 acts as 4 -> 4
        // R4: out-of-range ranks
        send(pack4(1, 2, 3, 4), 0, 4, "R4");   // -> all ones
        send(pack4(1, 2, 3, 4), 3, 2, "R4");   // -> zero
        send(pack4(1, 2, 3, 4), 1, 0, "R4");   // -> zero

        // Exhaustive sweep with per-window rank/size (R1 R3 R4 R5) and gaps (R7)
        for (int pass = 0; pass < 4; pass++) begin
            for (int w = 0; w < (1 << WIN); w++) begin
                if (((w + pass) % 9) == 8) idle();
                send(WIN'(w), (w * 5 + pass) % 8, (w * 3 + pass * 7 + 1) % 8, "");
            end
        end
        repeat (WIDTH + 3) idle();

        // R6: reset with windows in flight discards them
        send(pack4(7, 7, 7, 7), 1, 4, "R6");
        send(pack4(1, 1, 1, 1), 1, 4, "R6");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        exp_q.delete();
        due_q.delete();
        tag_q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R6 in-flight reset out_valid", int'(out_valid), 0);
        check(out_word == '0, "R6 in-flight reset out_word", int'(out_word), 0);
        @(negedge clk);
        last_word = '0;
        rst_n     = 1'b1;
        repeat (WIDTH + 4) idle();
        // Recovery after reset
        send(pack4(4, 6, 5, 0), 2, 3, "R6");   // -> 5
        repeat (WIDTH + 3) idle();
        check(exp_q.size() == 0, "R2 results drained", exp_q.size(), 0);

        finish_run();
    end

endmodule